// File: doc/BRIEF.md
# Byte-Lane Data Memory with Access Size Control

This block is a small data store addressed in bytes. It carries a 32-bit address, a 32-bit write word and a 32-bit read word. A 2-bit operation code chooses between a full-word load and three store widths: byte, halfword and word. A store updates only the byte lanes that its width and the low address bits select. The other bytes of the addressed word keep their values.

Data is little-endian: the byte at word offset 0 sits in bits 7:0. A load is combinational, so the word appears on the read port in the same cycle as the address. A store commits on the next rising clock edge. A store whose address does not fit its width raises an error flag in the same cycle and leaves storage untouched. The data path has no handshake and no back-pressure: every enabled access finishes in the cycle it is presented. The enable, the operation code and the error flag are plain level signals.

The depth is a parameter counted in 32-bit words. Address bits above the word index are ignored, so the store repeats through the address space.

Top module: `sized_byte_mem`

## Requirements
- R1: While reset is asserted, every stored byte is cleared to zero. A load after reset returns zero at every address, and the error flag is low.
- R2: With the enable high and operation code 00, the read port shows the word at address bits [IDX+1:2] in the same cycle, little-endian with offset 0 in bits 7:0. Address bits 1:0 are ignored, and storage is not changed.
- R3: Operation code 01 stores din[7:0] into the byte lane given by address bits 1:0 at the next rising edge. The other three lanes of that word keep their values.
- R4: Operation code 10 with address bit 0 clear stores din[15:0]. If address bit 1 is clear it goes to bits 15:0 of the word; if address bit 1 is set it goes to bits 31:16. The other half keeps its value.
- R5: Operation code 11 with address bits 1:0 equal to 00 replaces the whole word with din at the next rising edge.
- R6: A halfword store with address bit 0 set, or a word store with address bits 1:0 not 00, drives the error flag high in the same cycle and changes no stored byte. Loads and byte stores never raise the error flag.
- R7: With the enable low, no byte changes whatever the other inputs are, the read port is zero and the error flag is low.
- R8: During any store (enable high, operation code not 00) the read port is zero.
- R9: Address bits above the word index have no effect, so addresses that differ only in those bits reach the same word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; stores commit on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset that clears storage |
| en | input | 1 | Access enable |
| mc | input | 2 | Operation code: 00 load word, 01 store byte, 10 store halfword, 11 store word |
| addr | input | 32 | Byte address |
| din | input | 32 | Store data |
| dout | output | 32 | Loaded word, zero when no load is active |
| err | output | 1 | Misaligned store flag |

## Verification
The bench builds the block with a depth of four words, which gives a 16-byte space. This makes it possible to try every byte address under every store width and to read back the whole memory after each store. Each sweep sets a different pattern in the address bits above the index, so every store is also a check of the aliasing rule. A second sweep runs with the enable low, and loads at all four offsets show that the low address bits are ignored.

// File: rtl/mem_ctl_pkg.sv
`timescale 1ns/1ps
package mem_ctl_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int WORD_W = LANES * LANE_W;

  typedef enum logic [1:0] {
    OP_LOAD_WORD  = 2'b00,
    OP_STORE_BYTE = 2'b01,
    OP_STORE_HALF = 2'b10,
    OP_STORE_WORD = 2'b11
  } mem_op_e;
endpackage

// File: rtl/lane_select.sv
`timescale 1ns/1ps
// Turns operation code and byte offset into per-lane write strobes,
// lane-positioned write data and the misalignment flag.
module lane_select
  import mem_ctl_pkg::*;
(
  input  logic              en,
  input  logic [1:0]        op,
  input  logic [1:0]        ofs,
  input  logic [WORD_W-1:0] wdata,
  output logic [LANES-1:0]  lane_we,
  output logic [WORD_W-1:0] lane_data,
  output logic              misalign
);
  mem_op_e op_e;
  assign op_e = mem_op_e'(op);

  always_comb begin
    lane_we   = '0;
    lane_data = wdata;
    misalign  = 1'b0;
    if (en) begin
      unique case (op_e)
        OP_STORE_BYTE: begin
          lane_data = {LANES{wdata[LANE_W-1:0]}};
          lane_we   = LANES'(1) << ofs;
        end
        OP_STORE_HALF: begin
          lane_data = {2{wdata[2*LANE_W-1:0]}};
          misalign  = ofs[0];
          if (!ofs[0]) lane_we = ofs[1] ? 4'b1100 : 4'b0011;
        end
        OP_STORE_WORD: begin
          misalign = |ofs;
          if (ofs == 2'b00) lane_we = '1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/byte_bank.sv
`timescale 1ns/1ps
// One byte lane of storage: synchronous clear and write, combinational read.
module byte_bank #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [W-1:0]     wbyte,
  output logic [W-1:0]     rbyte
);
  logic [W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else if (we) begin
      cells[idx] <= wbyte;
    end
  end

  assign rbyte = cells[idx];
endmodule

// File: rtl/sized_byte_mem.sv
`timescale 1ns/1ps
module sized_byte_mem
  import mem_ctl_pkg::*;
#(
  parameter int DEPTH_WORDS = 16,
  parameter int ADDR_W      = 32,
  localparam int IDX_W      = $clog2(DEPTH_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [1:0]        mc,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout,
  output logic              err
);
  logic [IDX_W-1:0]  word_idx;
  logic [LANES-1:0]  lane_we;
  logic [WORD_W-1:0] lane_data;
  logic [WORD_W-1:0] rd_word;
  logic              misalign;
  logic              unused_addr_hi;

  assign word_idx       = addr[IDX_W+1:2];
  assign unused_addr_hi = ^addr[ADDR_W-1:IDX_W+2];

  lane_select u_sel (
    .en        (en),
    .op        (mc),
    .ofs       (addr[1:0]),
    .wdata     (din),
    .lane_we   (lane_we),
    .lane_data (lane_data),
    .misalign  (misalign)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    byte_bank #(.DEPTH(DEPTH_WORDS), .W(LANE_W)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (lane_we[g]),
      .idx   (word_idx),
      .wbyte (lane_data[g*LANE_W +: LANE_W]),
      .rbyte (rd_word[g*LANE_W +: LANE_W])
    );
  end

  assign dout = (en && mem_op_e'(mc) == OP_LOAD_WORD) ? rd_word : '0;
  assign err  = misalign;
endmodule

// File: rtl/sized_byte_mem_chk.sv
`timescale 1ns/1ps
module sized_byte_mem_chk #(
  parameter int IDX_W = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        en,
  input logic [1:0]  mc,
  input logic [31:0] addr,
  input logic [31:0] din,
  input logic [31:0] dout,
  input logic        err
);
  logic [IDX_W-1:0] idx;
  assign idx = addr[IDX_W+1:2];

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!rst_n) && en && mc == 2'b00) |-> dout == 32'h0);

  assert_load_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(en && mc == 2'b00) && en && mc == 2'b00 && $past(idx) == idx)
      |-> dout == $past(dout));

  assert_word_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(en && mc == 2'b11 && !err) && en && mc == 2'b00 && $past(idx) == idx)
      |-> dout == $past(din));

  assert_misaligned_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 2) && $past(en && mc == 2'b00, 2) && $past(en && err) &&
     $past(idx, 2) == idx && $past(idx) == idx && en && mc == 2'b00)
      |-> dout == $past(dout, 2));

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (dout == 32'h0 && !err));

  assert_store_no_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mc != 2'b00) |-> dout == 32'h0);
endmodule

bind sized_byte_mem sized_byte_mem_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .mc(mc), .addr(addr),
  .din(din), .dout(dout), .err(err)
);

// File: tb/sized_byte_mem_test.sv
`timescale 1ns/1ps
module sized_byte_mem_test;
  localparam int DEPTH = 4;
  localparam int BYTES = DEPTH * 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [1:0]  mc = 2'b00;
  logic [31:0] addr = '0;
  logic [31:0] din = '0;
  logic [31:0] dout;
  logic        err;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [7:0] model [BYTES];

  always #5 clk = ~clk;

  sized_byte_mem #(.DEPTH_WORDS(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .mc(mc), .addr(addr),
    .din(din), .dout(dout), .err(err)
  );

  function automatic logic [31:0] model_word(int w);
    return {model[4*w+3], model[4*w+2], model[4*w+1], model[4*w]};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Load every word; offset and high bits vary (R2, R9).
  task automatic readback(string tag, logic [31:0] hi, int k);
    for (int w = 0; w < DEPTH; w++) begin
      @(negedge clk);
      en = 1'b1; mc = 2'b00; din = 32'hDEAD_BEEF;
      addr = hi | 32'(w * 4 + ((w + k) & 3));
      #1 check(tag, dout, model_word(w));
    end
  endtask

  task automatic do_op(logic e, logic [1:0] m, logic [31:0] a, logic [31:0] d);
    logic exp_err;
    int b;
    @(negedge clk);
    en = e; mc = m; addr = a; din = d;
    exp_err = e && ((m == 2'b10 && a[0]) || (m == 2'b11 && a[1:0] != 2'b00));
    #1;
    check(e ? "R6 err flag" : "R7 err flag", {31'h0, err}, {31'h0, exp_err});
    check(e ? (m == 2'b00 ? "R2 load" : "R8 dout during store") : "R7 dout idle",
          dout, (e && m == 2'b00) ? model_word(int'(a[3:2])) : 32'h0);
    b = int'(a[3:0]);
    if (e && !exp_err) begin
      case (m)
        2'b01: model[b] = d[7:0];
        2'b10: begin model[b] = d[7:0]; model[b+1] = d[15:8]; end
        2'b11: for (int i = 0; i < 4; i++) model[b+i] = d[8*i +: 8];
        default: ;
      endcase
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < BYTES; i++) model[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1 check("R1 err after reset", {31'h0, err}, 32'h0);
    readback("R1 cleared", 32'h0, 0);
    for (int k = 1; k < 4; k++) readback("R2 offset ignored", 32'h0, k);

    for (int pass = 0; pass < 2; pass++) begin
      for (int a = 0; a < BYTES; a++) begin
        for (int m = 1; m < 4; m++) begin
          logic [31:0] hi, d;
          string tag;
          hi = 32'(pass * 3 + m) << (8 + a);
          d = 32'h9E37_79B9 * 32'(pass * 64 + a * 4 + m + 1);
          do_op(1'b1, 2'(m), hi | 32'(a), d);
          case (m)
            1: tag = "R3 byte store R9";
            2: tag = "R4 half store R9";
            default: tag = "R5 word store R9";
          endcase
          readback(tag, ~hi & 32'hFFFF_FFF0, a + m);
        end
      end
    end

    // Enable low: nothing changes (R7).
    for (int a = 0; a < BYTES; a++) begin
      for (int m = 0; m < 4; m++) do_op(1'b0, 2'(m), 32'(a), 32'h1234_5678 + 32'(a));
    end
    readback("R7 storage kept", 32'h0, 2);

    // Misaligned stores keep storage and flag error (R6).
    do_op(1'b1, 2'b11, 32'h5, 32'hFFFF_FFFF);
    do_op(1'b1, 2'b10, 32'hB, 32'hFFFF_FFFF);
    readback("R6 storage kept", 32'h0, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule